// File: doc/BRIEF.md
# Absolute Difference Unit with Accumulate

This block computes the absolute difference of two operands of a configurable width (64 bits by default). A mode input picks whether the operands are ordered as two's-complement or as unsigned values. The difference is always formed on a single adder: the smaller operand is inverted, and the larger operand plus one is added to it. An accumulate input adds that difference to a prior destination value. The sum wraps modulo 2^WIDTH, and its carry-out is dropped.

An operation is issued by holding `go` high for one clock. The result is registered and appears one cycle later, marked by `vld`. When the record input is set during the issue cycle, a 4-bit condition field goes with the result. It classifies the registered result as negative, positive or zero when read as a signed value, and it carries an external summary-overflow bit. Reset is asynchronous and active low, and its release is synchronised to the clock inside the block.

Top module: `absd_unit`

## Requirements
- R1: While reset is asserted and after it is released, with no issue made, `res` is 0, `cond` is 4'b0000 and `vld` is 0.
- R2: With `sgn`=0 and `acc`=0, the operands are ordered as unsigned values and `res` equals the larger minus the smaller.
- R3: With `sgn`=1 and `acc`=0, the operands are ordered as two's-complement values, and `res` equals the larger minus the smaller, modulo 2^WIDTH.
- R4: Equal operands give a difference of 0 in both orderings.
- R5: In unsigned mode, the operand pair 0 and all-ones gives all-ones, in either operand order.
- R6: With `acc`=1, `res` equals `prior` plus the difference, modulo 2^WIDTH, with the carry-out discarded. This holds for both orderings.
- R7: With `rec`=1, `cond` is {neg, pos, zero, so}. Bit 3 is the MSB of `res`. Bit 2 is set when `res` is nonzero and its MSB is clear. Bit 1 is set when `res` is zero. Bit 0 is `so_in` as sampled at issue.
- R8: With `rec`=0, `cond` is 4'b0000.
- R9: While `go` is low, `res` and `cond` hold their values whatever the other inputs do.
- R10: `vld` is high for exactly the cycle after each cycle with `go` high, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Issue; operands are captured on this clock |
| sgn | input | 1 | 1: signed ordering, 0: unsigned |
| acc | input | 1 | 1: add difference to `prior` |
| rec | input | 1 | 1: produce condition field |
| so_in | input | 1 | Summary-overflow bit copied into the field |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| prior | input | WIDTH | Prior destination value |
| res | output | WIDTH | Registered result |
| cond | output | 4 | Registered condition field |
| vld | output | 1 | Result issued in the previous cycle |

## Verification
The bench builds the unit with the default WIDTH of 64, so the full-width sign bit and the carry-out wrap are exercised at the size the unit is used at. Random operand pairs in all four combinations of ordering and accumulate reach mixed-sign pairs, where the signed and unsigned orderings disagree. The directed cases cover the extremes: all-ones against zero, the most-negative value, and accumulate sums that overflow.

// File: rtl/absd_pkg.sv
package absd_pkg;
  typedef struct packed {
    logic neg;
    logic pos;
    logic zero;
    logic so;
  } cond_t;
  localparam int COND_W = $bits(cond_t);
endpackage

// File: rtl/absd_compare.sv
module absd_compare #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sgn,
  output logic             a_lt_b
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH-1:0] ka;
  logic [WIDTH-1:0] kb;

  // flipping the sign bits turns a signed order into an unsigned one
  always_comb begin
    ka = a;
    kb = b;
    ka[MSB] = a[MSB] ^ sgn;
    kb[MSB] = b[MSB] ^ sgn;
    a_lt_b = ka < kb;
  end

  always_comb begin
    if (a == b) a_r4_not_less: assert (!a_lt_b);
  end
endmodule

// File: rtl/absd_diff.sv
module absd_diff #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             a_lt_b,
  output logic [WIDTH-1:0] diff
);
  logic [WIDTH-1:0] small_op;
  logic [WIDTH-1:0] large_op;

  always_comb begin
    small_op = a_lt_b ? a : b;
    large_op = a_lt_b ? b : a;
    diff     = ~small_op + large_op + {{(WIDTH-1){1'b0}}, 1'b1};
  end

  always_comb begin
    if (a == b) a_r4_zero_diff: assert (diff == '0);
  end
endmodule

// File: rtl/absd_accum.sv
module absd_accum #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] diff,
  input  logic [WIDTH-1:0] prior,
  input  logic             acc,
  output logic [WIDTH-1:0] sum
);
  logic [WIDTH:0] wide;

  always_comb begin
    wide = {1'b0, acc ? prior : {WIDTH{1'b0}}} + {1'b0, diff};
    sum  = wide[WIDTH-1:0];
  end
endmodule

// File: rtl/absd_cond.sv
module absd_cond
  import absd_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] value,
  input  logic             rec,
  input  logic             so_in,
  output cond_t            cond
);
  logic is_zero;

  always_comb begin
    is_zero = (value == '0);
    cond    = '0;
    if (rec) begin
      cond.neg  = value[WIDTH-1];
      cond.pos  = !value[WIDTH-1] && !is_zero;
      cond.zero = is_zero;
      cond.so   = so_in;
    end
  end

  always_comb begin
    if (rec) a_r7_one_class: assert ($countones({cond.neg, cond.pos, cond.zero}) == 1);
  end
endmodule

// File: rtl/absd_unit.sv
module absd_unit
  import absd_pkg::*;
#(
  parameter int WIDTH = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic               sgn,
  input  logic               acc,
  input  logic               rec,
  input  logic               so_in,
  input  logic [WIDTH-1:0]   op_a,
  input  logic [WIDTH-1:0]   op_b,
  input  logic [WIDTH-1:0]   prior,
  output logic [WIDTH-1:0]   res,
  output logic [COND_W-1:0]  cond,
  output logic               vld
);
  logic [1:0]       rst_pipe;
  logic             rst_ok_n;
  logic             a_lt_b;
  logic [WIDTH-1:0] diff;
  logic [WIDTH-1:0] sum;
  cond_t            cond_d;
  logic [WIDTH-1:0] res_q, res_d;
  cond_t            cond_q, cond_d2;
  logic             vld_q, vld_d;

  // release of reset synchronised to clk
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ok_n = rst_pipe[1];

  absd_compare #(.WIDTH(WIDTH)) u_cmp (
    .a(op_a), .b(op_b), .sgn(sgn), .a_lt_b(a_lt_b)
  );

  absd_diff #(.WIDTH(WIDTH)) u_diff (
    .a(op_a), .b(op_b), .a_lt_b(a_lt_b), .diff(diff)
  );

  absd_accum #(.WIDTH(WIDTH)) u_acc (
    .diff(diff), .prior(prior), .acc(acc), .sum(sum)
  );

  absd_cond #(.WIDTH(WIDTH)) u_cond (
    .value(sum), .rec(rec), .so_in(so_in), .cond(cond_d)
  );

  always_comb begin
    res_d   = res_q;
    cond_d2 = cond_q;
    vld_d   = go;
    if (go) begin
      res_d   = sum;
      cond_d2 = cond_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ok_n) begin
    if (!rst_ok_n) begin
      res_q  <= '0;
      cond_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      res_q  <= res_d;
      cond_q <= cond_d2;
      vld_q  <= vld_d;
    end
  end

  assign res  = res_q;
  assign cond = cond_q;
  assign vld  = vld_q;

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !go |=> ($stable(res) && $stable(cond)));
  a_r10_valid: assert property (@(posedge clk) disable iff (!rst_ok_n)
    go |=> vld);
  a_r10_idle: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !go |=> !vld);
  a_r8_no_record: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (go && !rec) |=> (cond == '0));
  a_r2_plain_unsigned_order: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (go && !sgn && !acc && (op_a >= op_b)) |=> (res == $past(op_a) - $past(op_b)));
endmodule

// File: tb/test_absd_unit.sv
module test_absd_unit;
  localparam int W = 64;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic go, sgn, acc, rec, so_in;
  logic [W-1:0] op_a, op_b, prior;
  logic [W-1:0] res;
  logic [3:0]   cond;
  logic         vld;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  absd_unit #(.WIDTH(W)) i_absd_unit (
    .clk(clk), .rst_n(rst_n), .go(go), .sgn(sgn), .acc(acc), .rec(rec),
    .so_in(so_in), .op_a(op_a), .op_b(op_b), .prior(prior),
    .res(res), .cond(cond), .vld(vld)
  );

  function automatic logic [W-1:0] ref_diff(logic [W-1:0] a, logic [W-1:0] b, logic s);
    logic less;
    less = s ? ($signed(a) < $signed(b)) : (a < b);
    return less ? b - a : a - b;
  endfunction

  function automatic logic [3:0] ref_cond(logic [W-1:0] v, logic r, logic so);
    if (!r) return 4'b0000;
    if (v == '0) return {3'b001, so};
    if (v[W-1]) return {3'b100, so};
    return {3'b010, so};
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(string req, logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] p,
                       logic s, logic ac, logic r, logic so);
    logic [W-1:0] e;
    @(negedge clk);
    go = 1'b1; op_a = a; op_b = b; prior = p; sgn = s; acc = ac; rec = r; so_in = so;
    e = ref_diff(a, b, s) + (ac ? p : '0);
    @(negedge clk);
    go = 1'b0;
    chk(req, res, e);
    chk({req, " cond"}, {{(W-4){1'b0}}, cond}, {{(W-4){1'b0}}, ref_cond(e, r, so)});
    chk("R10 vld", {{(W-1){1'b0}}, vld}, {{(W-1){1'b0}}, 1'b1});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] keep_r;
    logic [3:0]   keep_c;
    void'($urandom(32'd2024));
    rst_n = 1'b0; go = 1'b0; sgn = 1'b0; acc = 1'b0; rec = 1'b0; so_in = 1'b0;
    op_a = '0; op_b = '0; prior = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 res", res, '0);
    chk("R1 cond", {{(W-4){1'b0}}, cond}, '0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 vld", {{(W-1){1'b0}}, vld}, '0);
    chk("R1 res after release", res, '0);

    // R2 unsigned plain
    issue("R2", 64'd100, 64'd30, '0, 0, 0, 0, 0);
    issue("R2", 64'd30, 64'd100, '0, 0, 0, 0, 0);
    issue("R2", 64'h8000_0000_0000_0000, 64'd1, '0, 0, 0, 0, 0);
    // R3 signed plain
    issue("R3", -64'sd5, 64'd7, '0, 1, 0, 0, 0);
    issue("R3", 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, '0, 1, 0, 0, 0);
    issue("R3", 64'd7, -64'sd5, '0, 1, 0, 0, 0);
    // R4 equal
    issue("R4", 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, '0, 0, 0, 0, 0);
    issue("R4", {W{1'b1}}, {W{1'b1}}, '0, 1, 0, 0, 0);
    // R5 extremes
    issue("R5", '0, {W{1'b1}}, '0, 0, 0, 0, 0);
    chk("R5 value", res, {W{1'b1}});
    issue("R5", {W{1'b1}}, '0, '0, 0, 0, 0, 0);
    chk("R5 value", res, {W{1'b1}});
    // R6 accumulate with wrap
    issue("R6", 64'd10, 64'd3, {W{1'b1}}, 0, 1, 0, 0);
    chk("R6 wrap", res, 64'd6);
    issue("R6", -64'sd2, 64'd2, 64'd100, 1, 1, 0, 0);
    // R7 record classes
    issue("R7 zero", 64'd9, 64'd9, '0, 0, 0, 1, 1);
    chk("R7 zero field", {{(W-4){1'b0}}, cond}, 64'b0011);
    issue("R7 neg", '0, {W{1'b1}}, '0, 0, 0, 1, 0);
    chk("R7 neg field", {{(W-4){1'b0}}, cond}, 64'b1000);
    issue("R7 pos", 64'd4, 64'd1, '0, 0, 0, 1, 1);
    chk("R7 pos field", {{(W-4){1'b0}}, cond}, 64'b0101);
    // R8 no record
    issue("R8", 64'd4, 64'd1, '0, 0, 0, 0, 1);
    chk("R8 field", {{(W-4){1'b0}}, cond}, '0);

    // R9 hold while idle
    issue("R9 setup", 64'd50, 64'd20, '0, 0, 0, 1, 1);
    keep_r = res; keep_c = cond;
    @(negedge clk);
    op_a = 64'd999; op_b = 64'd1; rec = 1'b0; acc = 1'b1; prior = 64'd77;
    @(negedge clk);
    chk("R9 res", res, keep_r);
    chk("R9 cond", {{(W-4){1'b0}}, cond}, {{(W-4){1'b0}}, keep_c});
    chk("R10 idle vld", {{(W-1){1'b0}}, vld}, '0);

    // random across all four modes
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb, rp;
      ra = {$urandom, $urandom};
      rb = (i % 7 == 0) ? ra : {$urandom, $urandom};
      rp = {$urandom, $urandom};
      case (i % 4)
        0: issue("R2 rand", ra, rb, rp, 0, 0, 1, i[0]);
        1: issue("R3 rand", ra, rb, rp, 1, 0, 1, i[1]);
        2: issue("R6 rand unsigned", ra, rb, rp, 0, 1, 1, i[2]);
        default: issue("R6 rand signed", ra, rb, rp, 1, 1, 0, i[3]);
      endcase
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule